// File: doc/BRIEF.md
# Run-Time Configurable Serial Transmitter

This block sends bytes on an asynchronous serial line. The frame format and the bit rate come from a packed 8-bit control word. The block captures that word on every clock edge while its internal reset is active. It captures it again on any edge where the load strobe is high. A host hands over one byte at a time with a valid/ready handshake. The block then drives a start bit, the data bits, an optional parity bit and one or two stop bits.

A single flop generates the internal reset. It is set as soon as the external active-low reset falls. It is cleared on the first clock edge after that reset rises, so the internal reset releases in step with the clock. Each frame keeps a private copy of the format and the bit-period divisor, taken when the byte is accepted. A reload that arrives during a frame therefore changes only the frames that follow.

Top module: `uart_tx_cfg`

## Requirements
- R1: A frame starts with one low start bit. The data bits follow, least significant first. Control bits [4:3] give the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above that length are not sent.
- R2: Every bit lasts exactly REF_COUNT / rate clock cycles, which is the divisor REF_COUNT / rate - 1 plus one. Control bits [7:5] pick the rate as an index into the eight-entry BAUD_RATES parameter.
- R3: When control bit 2 is 1, a parity bit follows the data. Control bit 1 sets the parity type: 0 makes the count of ones in data plus parity even, and 1 makes it odd. When control bit 2 is 0, no parity bit is sent.
- R4: After the data or parity bit the line is held high for one stop bit when control bit 0 is 0, and for two stop bits when it is 1.
- R5: The idle line is high and ready is high while idle. Ready goes low from the clock edge that accepts a byte until the last stop bit ends. It goes high again exactly one frame length after that edge.
- R6: The control word is captured on each rising edge while the internal reset is active, and on each edge where the load strobe is high. At all other times a change on the control input has no effect on the format of the next frame.
- R7: A capture during a frame leaves that frame unchanged. The new format applies from the next accepted byte.
- R8: The internal reset asserts as soon as rst_ni falls, with no clock edge needed. It releases on the first rising edge after rst_ni rises. While it is active, tx_o is high and ready_o is low.
- R9: Valid asserted while ready is low does not start or queue a frame. The line stays idle after the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Control word: rate [7:5], length [4:3], parity enable [2], odd parity [1], two stop bits [0] |
| load_i | input | 1 | Capture strobe for ctrl_i |
| valid_i | input | 1 | Byte offered |
| data_i | input | 8 | Byte to send |
| ready_o | output | 1 | Byte accepted on an edge where valid_i and ready_o are both high |
| tx_o | output | 1 | Serial line, high when idle |

## Verification
The assertions check the following on every cycle:
- the start bit is low and the stop bits are high;
- the data-bit counter stays within the latched length;
- the bit counter never exceeds its divisor;
- the frame copy of the format stays stable while a frame is running;
- ready drops after a byte is accepted;
- the internal reset releases one edge after rst_ni rises and keeps the line quiet while active.

Other behaviour can only be shown by the bench scenarios that decode the line:
- the bit order and the parity value;
- the exact bit-period length at each of the eight rates;
- that a mid-frame reload is deferred to the next frame;
- that control changes without a strobe are ignored;
- that a valid pulse seen while busy is dropped.

// File: rtl/uart_txc_pkg.sv
`timescale 1ns/1ps
package uart_txc_pkg;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned N_RATES = 1 << SEL_W;

  typedef struct packed {
    logic [2:0] len_m1;    // data bits minus one, 4..7
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } fmt_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
  } tx_state_e;

  function automatic fmt_t ctrl_to_fmt(logic [4:0] w);
    fmt_t f;
    f.len_m1   = 3'd4 + {1'b0, w[4:3]};
    f.par_en   = w[2];
    f.par_odd  = w[1];
    f.two_stop = w[0];
    return f;
  endfunction

endpackage

// File: rtl/txc_rst_sync.sv
`timescale 1ns/1ps
module txc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_o
);
  logic rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b1;
    else         rst_q <= 1'b0;
  end

  assign rst_o = rst_q;

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> !rst_o);

endmodule

// File: rtl/txc_cfg_reg.sv
`timescale 1ns/1ps
module txc_cfg_reg
  import uart_txc_pkg::*;
#(
  parameter int unsigned REF_COUNT = 1843200,
  parameter int unsigned BAUD_RATES [N_RATES] = '{1200, 2400, 4800, 9600,
                                                   19200, 38400, 57600, 115200},
  parameter int unsigned DIV_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [7:0]       ctrl_i,
  output fmt_t             fmt_o,
  output logic [DIV_W-1:0] div_o
);
  fmt_t             fmt_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_tab [N_RATES];

  for (genvar g = 0; g < N_RATES; g++) begin : g_div
    assign div_tab[g] = DIV_W'(REF_COUNT / BAUD_RATES[g] - 1);
  end

  // synchronous capture; reset acts as a load
  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) begin
      fmt_q <= ctrl_to_fmt(ctrl_i[4:0]);
      sel_q <= ctrl_i[7:5];
    end
  end

  assign fmt_o = fmt_q;
  assign div_o = div_tab[sel_q];

  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> ($stable(fmt_q) && $stable(sel_q)));

endmodule

// File: rtl/txc_baud_gen.sv
`timescale 1ns/1ps
module txc_baud_gen #(
  parameter int unsigned DIV_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)                      cnt_q <= '0;
    else if (restart_i || tick_o)   cnt_q <= div_i;
    else                            cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !restart_i |-> (cnt_q <= div_i));

endmodule

// File: rtl/txc_tx_fsm.sv
`timescale 1ns/1ps
module txc_tx_fsm
  import uart_txc_pkg::*;
#(
  parameter int unsigned DIV_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  fmt_t             fmt_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic             tick_i,
  output logic             restart_o,
  output logic [DIV_W-1:0] div_o,
  output logic             ready_o,
  output logic             tx_o
);
  tx_state_e        state_q;
  logic             tx_q;
  logic [7:0]       shreg_q;
  logic [2:0]       bit_cnt_q;
  logic             stop_cnt_q;
  logic             par_q;
  fmt_t             frm_q;
  logic [DIV_W-1:0] frm_div_q;
  logic             accept;

  assign accept    = (state_q == TX_IDLE) && valid_i;
  assign restart_o = accept;
  assign div_o     = accept ? div_i : frm_div_q;  // new divisor seeds the start bit

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      state_q    <= TX_IDLE;
      tx_q       <= 1'b1;
      shreg_q    <= '0;
      bit_cnt_q  <= '0;
      stop_cnt_q <= 1'b0;
      par_q      <= 1'b0;
      frm_q      <= '0;
      frm_div_q  <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (valid_i) begin
          state_q   <= TX_START;
          tx_q      <= 1'b0;
          shreg_q   <= data_i;
          frm_q     <= fmt_i;
          frm_div_q <= div_i;
        end
        TX_START: if (tick_i) begin
          state_q   <= TX_DATA;
          tx_q      <= shreg_q[0];
          par_q     <= shreg_q[0];
          shreg_q   <= shreg_q >> 1;
          bit_cnt_q <= '0;
        end
        TX_DATA: if (tick_i) begin
          if (bit_cnt_q == frm_q.len_m1) begin
            stop_cnt_q <= 1'b0;
            if (frm_q.par_en) begin
              state_q <= TX_PARITY;
              tx_q    <= par_q ^ frm_q.par_odd;
            end else begin
              state_q <= TX_STOP;
              tx_q    <= 1'b1;
            end
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            tx_q      <= shreg_q[0];
            par_q     <= par_q ^ shreg_q[0];
            shreg_q   <= shreg_q >> 1;
          end
        end
        TX_PARITY: if (tick_i) begin
          state_q <= TX_STOP;
          tx_q    <= 1'b1;
        end
        TX_STOP: if (tick_i) begin
          if (stop_cnt_q == frm_q.two_stop) state_q <= TX_IDLE;
          else                              stop_cnt_q <= 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == TX_IDLE) && !rst_i;
  assign tx_o    = tx_q;

  assert_start_low_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == TX_START) |-> !tx_q);

  assert_bit_cnt_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == TX_DATA) |-> (bit_cnt_q <= frm_q.len_m1));

  assert_stop_high_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == TX_STOP) |-> tx_q);

  assert_busy_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && ready_o) |=> !ready_o);

  assert_idle_line_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |-> tx_o);

  assert_frame_fmt_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != TX_IDLE && $past(state_q) != TX_IDLE)
      |-> ($stable(frm_q) && $stable(frm_div_q)));

endmodule

// File: rtl/uart_tx_cfg.sv
`timescale 1ns/1ps
module uart_tx_cfg
  import uart_txc_pkg::*;
#(
  parameter int unsigned REF_COUNT = 1843200,
  parameter int unsigned BAUD_RATES [N_RATES] = '{1200, 2400, 4800, 9600,
                                                   19200, 38400, 57600, 115200}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ctrl_i,
  input  logic       load_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       tx_o
);
  localparam int unsigned DIV_W = $clog2(REF_COUNT + 1);

  logic             sys_rst;
  fmt_t             fmt;
  logic [DIV_W-1:0] cfg_div;
  logic [DIV_W-1:0] run_div;
  logic             restart;
  logic             tick;

  txc_rst_sync i_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_o (sys_rst)
  );

  txc_cfg_reg #(
    .REF_COUNT (REF_COUNT),
    .BAUD_RATES(BAUD_RATES),
    .DIV_W     (DIV_W)
  ) i_cfg (
    .clk_i (clk_i),
    .rst_i (sys_rst),
    .load_i(load_i),
    .ctrl_i(ctrl_i),
    .fmt_o (fmt),
    .div_o (cfg_div)
  );

  txc_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk_i    (clk_i),
    .rst_i    (sys_rst),
    .restart_i(restart),
    .div_i    (run_div),
    .tick_o   (tick)
  );

  txc_tx_fsm #(.DIV_W(DIV_W)) i_fsm (
    .clk_i    (clk_i),
    .rst_i    (sys_rst),
    .fmt_i    (fmt),
    .div_i    (cfg_div),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .tick_i   (tick),
    .restart_o(restart),
    .div_o    (run_div),
    .ready_o  (ready_o),
    .tx_o     (tx_o)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst |-> (tx_o && !ready_o));

endmodule

// File: tb/test_uart_tx_cfg.sv
`timescale 1ns/1ps
module test_uart_tx_cfg;

  localparam int unsigned REF = 120;
  localparam int unsigned TB_RATES [8] = '{10, 12, 20, 24, 30, 40, 60, 120};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [7:0] ctrl = 8'h00;
  logic       load = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = 8'h00;
  logic       ready;
  logic       tx;

  int         checks = 0;
  int         errors = 0;
  int         cur = 0;
  logic [7:0] model;

  always #2 clk = ~clk;  // 250 MHz

  uart_tx_cfg #(.REF_COUNT(REF), .BAUD_RATES(TB_RATES)) i_uart_tx_cfg (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .load_i (load),
    .valid_i(valid),
    .data_i (data),
    .ready_o(ready),
    .tx_o   (tx)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int period(input logic [7:0] c);
    return REF / TB_RATES[c[7:5]];
  endfunction

  task automatic adv(input int t);
    while (cur < t) begin
      @(negedge clk);
      cur++;
    end
  endtask

  // ends at the negedge after the accepting edge (offset 0)
  task automatic send(input logic [7:0] d);
    @(negedge clk);
    valid = 1'b1;
    data  = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
    data  = 8'($urandom);
    cur   = 0;
  endtask

  task automatic check_frame(input logic [7:0] c, input logic [7:0] d);
    int    p = period(c);
    int    n = 5 + int'(c[4:3]);
    logic  b [12];
    string r [12];
    int    len = 0;
    logic [7:0] m = d & (8'hFF >> (8 - n));
    b[len] = 1'b0; r[len] = "R1"; len++;
    for (int i = 0; i < n; i++) begin
      b[len] = d[i]; r[len] = "R1"; len++;
    end
    if (c[2]) begin
      b[len] = (^m) ^ c[1]; r[len] = "R3"; len++;
    end
    b[len] = 1'b1; r[len] = "R4"; len++;
    if (c[0]) begin
      b[len] = 1'b1; r[len] = "R4"; len++;
    end
    chk(!ready, "R5", int'(ready), 0);
    for (int k = 0; k < len; k++) begin
      adv(k * p + p / 2);
      chk(tx === b[k], r[k], int'(tx), int'(b[k]));
      if (k == 0) begin
        adv(p - 1);
        chk(tx === 1'b0, "R2", int'(tx), 0);
        adv(p);
        chk(tx === b[1], "R2", int'(tx), int'(b[1]));
      end
    end
    adv(len * p - 1);
    chk(!ready, "R5", int'(ready), 0);
    adv(len * p);
    chk(ready && tx, "R5", int'({ready, tx}), 3);
  endtask

  task automatic load_cfg(input logic [7:0] c);
    @(negedge clk);
    ctrl = c;
    load = 1'b1;
    @(negedge clk);
    load  = 1'b0;
    model = c;
  endtask

  task automatic frame(input logic [7:0] d);
    send(d);
    check_frame(model, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'h1c6e);
    ctrl = 8'b110_10_1_1_1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx === 1'b1, "R8", int'(tx), 1);
    chk(ready === 1'b0, "R8", int'(ready), 0);
    rst_ni = 1'b1;
    #1 chk(ready === 1'b0, "R8", int'(ready), 0);
    @(negedge clk);
    chk(ready === 1'b1, "R8", int'(ready), 1);
    chk(tx === 1'b1, "R5", int'(tx), 1);
    model = 8'b110_10_1_1_1;  // captured during reset (R6)

    // R6: control change without strobe has no effect
    ctrl = 8'b000_00_0_0_0;
    frame(8'hA5);

    // R2: every rate
    for (int s = 0; s < 8; s++) begin
      load_cfg({3'(s), 2'b11, 3'b000});
      frame(8'($urandom));
    end

    // R1/R3/R4: all lengths, parity modes and stop counts
    for (int f = 0; f < 32; f++) begin
      load_cfg({3'(7 - (f % 3)), 5'(f)});
      frame(8'($urandom));
    end

    // R7: reload mid-frame
    load_cfg(8'b000_11_1_0_1);
    send(8'h3C);
    fork
      check_frame(8'b000_11_1_0_1, 8'h3C);
      begin
        repeat (5) @(negedge clk);
        ctrl = 8'b111_00_1_1_0;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
      end
    join
    model = 8'b111_00_1_1_0;
    frame(8'hC3);

    // R9: valid while busy is dropped
    load_cfg(8'b010_01_0_0_0);
    send(8'h55);
    fork
      check_frame(model, 8'h55);
      begin
        @(negedge clk);
        valid = 1'b1;
        data  = 8'h0F;
        repeat (3) @(negedge clk);
        valid = 1'b0;
      end
    join
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(ready && tx, "R9", int'({ready, tx}), 3);
    end

    // R8: asynchronous reset in mid-frame
    load_cfg(8'b001_11_0_0_0);
    send(8'h00);
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    #1 chk(tx === 1'b1, "R8", int'(tx), 1);
    chk(ready === 1'b0, "R8", int'(ready), 0);
    @(negedge clk);
    ctrl   = 8'b100_10_1_0_1;
    rst_ni = 1'b1;
    model  = ctrl;
    @(negedge clk);
    chk(ready === 1'b1, "R8", int'(ready), 1);
    frame(8'h96);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 2 == 0) load_cfg(8'($urandom));
      else ctrl = 8'($urandom);  // no strobe: ignored (R6)
      frame(8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule